// File: doc/BRIEF.md
# Clock Calendar Initialization-Mode Controller

This block governs when a real-time clock counter may run. Software raises an initialization request to freeze the counter and load new settings. It then polls a ready flag before it writes. When it drops the request, the new prescaler settings take effect after a fixed restart delay. The block also builds the one-second tick from two cascaded down-counting prescalers: an asynchronous stage that feeds a synchronous stage. It keeps a sub-second value that software can read, and it holds a 12/24-hour format bit that can be changed only while the block is initialized.

The controller is a four-state machine that runs in the counting clock. In `ST_RUN` the prescalers count. When a request is seen, `ST_RUN -> ST_ENTER` is taken. `ST_ENTER -> ST_INIT` follows once the entry latency has passed, and `ST_ENTER -> ST_RESTART` is taken instead if the request is withdrawn early. `ST_INIT -> ST_RESTART` is taken when the request is dropped. `ST_RESTART -> ST_RUN` is taken after the restart latency, and on that edge the prescaler reload values and the sub-second mode are captured. Reset places the machine in `ST_INIT`, so the counter starts stopped.

Mode select `00` is BCD mode: the sub-second output shows the live synchronous prescaler count. The other three codes (`01`, `10`, `11`) are binary or mixed modes: the sub-second output is a separate down-counter that starts at all ones.

Top module: `rtc_initctl`

## Requirements
- R1: After reset, `init_flag` is 1, `count_en` is 0, `tick_1hz` is 0, `subsec` is 0 and `fmt_12h` is 0.
- R2: When `init_req` is sampled high in `ST_RUN`, `count_en` falls after that same edge and `init_flag` rises exactly 2 clock edges later, provided the request is still high.
- R3: While `count_en` is 0, `subsec` and both prescaler counts hold their values.
- R4: After `init_req` is sampled low in `ST_INIT`, `count_en` rises after the 5th edge, counting that edge as the first. On that edge `prediv_a`, `prediv_s` and `mode_sel` are captured as the new settings.
- R5: If `init_req` falls while in `ST_ENTER`, `init_flag` never rises and `count_en` rises with the same 4-edge restart delay as in R4.
- R6: A request raised during `ST_RESTART` does not shorten the restart. Counting runs for exactly one cycle, and then the entry sequence of R2 begins.
- R7: With captured settings A and S, `tick_1hz` pulses for one cycle every (A+1)*(S+1) counting cycles. The first pulse comes in counting cycle (A+1)*(S+1)-1, where the first cycle with `count_en` high is cycle 0.
- R8: With mode code `00` (BCD), `subsec` equals the synchronous prescaler count, zero-extended. It starts at S and steps down by one on each wrap of the asynchronous stage, reloading S after 0.
- R9: With mode code `01`, `10` or `11`, `subsec` starts at all ones and decrements by one on each wrap of the asynchronous stage.
- R10: `fmt_12h` takes `fmt_wdata` on an edge where `fmt_wr` is high only if `init_flag` is high. Otherwise it is unchanged.
- R11: `tick_1hz` is never high while `count_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Initialization request from software |
| prediv_a | input | A_W | Asynchronous prescaler reload value |
| prediv_s | input | S_W | Synchronous prescaler reload value |
| mode_sel | input | 2 | Sub-second mode: 00 BCD, others binary or mixed |
| fmt_wr | input | 1 | Write strobe for the hour-format bit |
| fmt_wdata | input | 1 | New hour-format value (1 = 12-hour) |
| init_flag | output | 1 | High in `ST_INIT`: settings may be written |
| count_en | output | 1 | High in `ST_RUN`: prescalers advance |
| tick_1hz | output | 1 | One-cycle pulse per second |
| subsec | output | SS_W | Sub-second value |
| fmt_12h | output | 1 | Stored hour-format bit |

## Verification
On every cycle, the bound checker confirms that the tick never fires while counting is stopped and that the ready flag and the counting enable are never high together. It also confirms that the sub-second value and the format bit hold whenever they must, and that each rise of the flag follows two sampled request cycles. Only the directed scenarios can show the exact latencies counted in edges: entry, restart, an aborted entry and a request raised during restart. The same holds for the tick period produced by different captured prescaler pairs and for the sub-second sequences in BCD and binary modes.

// File: rtl/rtc_initctl_pkg.sv
package rtc_initctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_ENTER   = 2'd1,
        ST_INIT    = 2'd2,
        ST_RESTART = 2'd3
    } ctl_state_e;

    localparam logic [1:0] MODE_BCD = 2'b00;

endpackage

// File: rtl/rtc_init_fsm.sv
module rtc_init_fsm
    import rtc_initctl_pkg::*;
#(
    parameter int ENTER_LAT   = 2,
    parameter int RESTART_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_req,
    output logic init_flag,
    output logic count_en,
    output logic load_pulse
);

    localparam int DLY_W = $clog2(ENTER_LAT + RESTART_LAT + 1);
    localparam logic [DLY_W-1:0] ENTER_LAST   = DLY_W'(ENTER_LAT - 1);
    localparam logic [DLY_W-1:0] RESTART_LAST = DLY_W'(RESTART_LAT - 1);

    ctl_state_e       state_q, state_d;
    logic [DLY_W-1:0] dly_q, dly_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            dly_q   <= dly_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        dly_d   = dly_q;
        unique case (state_q)
            ST_RUN: begin
                if (init_req) begin
                    state_d = ST_ENTER;
                    dly_d   = '0;
                end
            end
            ST_ENTER: begin
                if (!init_req) begin
                    state_d = ST_RESTART;
                    dly_d   = '0;
                end else if (dly_q == ENTER_LAST) begin
                    state_d = ST_INIT;
                    dly_d   = '0;
                end else begin
                    dly_d = dly_q + 1'b1;
                end
            end
            ST_INIT: begin
                if (!init_req) begin
                    state_d = ST_RESTART;
                    dly_d   = '0;
                end
            end
            ST_RESTART: begin
                if (dly_q == RESTART_LAST) begin
                    state_d = ST_RUN;
                    dly_d   = '0;
                end else begin
                    dly_d = dly_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_INIT;
                dly_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        init_flag  = 1'b0;
        count_en   = 1'b0;
        load_pulse = 1'b0;
        unique case (state_q)
            ST_RUN:     count_en   = 1'b1;
            ST_ENTER:   ;
            ST_INIT:    init_flag  = 1'b1;
            ST_RESTART: load_pulse = (dly_q == RESTART_LAST);
            default:    ;
        endcase
    end

endmodule

// File: rtl/rtc_prescale_stage.sv
module rtc_prescale_stage #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] reload_in,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] reload_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            reload_q <= reload_in;
            cnt_q    <= reload_in;
        end else if (step) begin
            if (cnt_q == '0) begin
                cnt_q <= reload_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt  = cnt_q;
    assign wrap = step && (cnt_q == '0);

endmodule

// File: rtl/rtc_subsec.sv
module rtc_subsec
    import rtc_initctl_pkg::*;
#(
    parameter int S_W  = 15,
    parameter int SS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [1:0]      mode_in,
    input  logic            step,
    input  logic [S_W-1:0]  sync_cnt,
    output logic [SS_W-1:0] subsec
);

    logic [1:0]      mode_q;
    logic [SS_W-1:0] bin_q;
    logic [SS_W-1:0] bcd_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_BCD;
            bin_q  <= '0;
        end else if (load) begin
            mode_q <= mode_in;
            bin_q  <= '1;
        end else if (step) begin
            bin_q  <= bin_q - 1'b1;
        end
    end

    generate
        if (SS_W > S_W) begin : g_wide
            assign bcd_view = {{(SS_W - S_W){1'b0}}, sync_cnt};
        end else begin : g_narrow
            assign bcd_view = sync_cnt[SS_W-1:0];
        end
    endgenerate

    assign subsec = (mode_q == MODE_BCD) ? bcd_view : bin_q;

endmodule

// File: rtl/rtc_initctl.sv
module rtc_initctl #(
    parameter int A_W         = 7,
    parameter int S_W         = 15,
    parameter int SS_W        = 32,
    parameter int ENTER_LAT   = 2,
    parameter int RESTART_LAT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_req,
    input  logic [A_W-1:0]  prediv_a,
    input  logic [S_W-1:0]  prediv_s,
    input  logic [1:0]      mode_sel,
    input  logic            fmt_wr,
    input  logic            fmt_wdata,
    output logic            init_flag,
    output logic            count_en,
    output logic            tick_1hz,
    output logic [SS_W-1:0] subsec,
    output logic            fmt_12h
);

    logic           load_pulse;
    logic [A_W-1:0] a_cnt;
    logic           a_wrap;
    logic [S_W-1:0] s_cnt;
    logic           s_wrap;
    logic           fmt_q;

    rtc_init_fsm #(
        .ENTER_LAT   (ENTER_LAT),
        .RESTART_LAT (RESTART_LAT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_req   (init_req),
        .init_flag  (init_flag),
        .count_en   (count_en),
        .load_pulse (load_pulse)
    );

    rtc_prescale_stage #(.W(A_W)) u_async (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_pulse),
        .reload_in (prediv_a),
        .step      (count_en),
        .cnt       (a_cnt),
        .wrap      (a_wrap)
    );

    rtc_prescale_stage #(.W(S_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_pulse),
        .reload_in (prediv_s),
        .step      (a_wrap),
        .cnt       (s_cnt),
        .wrap      (s_wrap)
    );

    rtc_subsec #(.S_W(S_W), .SS_W(SS_W)) u_subsec (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_pulse),
        .mode_in  (mode_sel),
        .step     (a_wrap),
        .sync_cnt (s_cnt),
        .subsec   (subsec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= 1'b0;
        end else if (fmt_wr && init_flag) begin
            fmt_q <= fmt_wdata;
        end
    end

    assign tick_1hz = s_wrap;
    assign fmt_12h  = fmt_q;

    logic unused_a;
    assign unused_a = ^a_cnt;

endmodule

// File: rtl/rtc_initctl_chk.sv
module rtc_initctl_chk #(
    parameter int SS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            init_req,
    input logic            init_flag,
    input logic            count_en,
    input logic            tick_1hz,
    input logic [SS_W-1:0] subsec,
    input logic            fmt_12h
);

    // R11
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> count_en);

    // R2
    flag_excl_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_flag |-> !count_en);

    // R3
    frozen_subsec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> (count_en || $stable(subsec)));

    // R10
    fmt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_flag |=> $stable(fmt_12h));

    // R2
    flag_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_flag) |-> ($past(init_req, 1) && $past(init_req, 2)));

endmodule

bind rtc_initctl rtc_initctl_chk #(.SS_W(SS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_req  (init_req),
    .init_flag (init_flag),
    .count_en  (count_en),
    .tick_1hz  (tick_1hz),
    .subsec    (subsec),
    .fmt_12h   (fmt_12h)
);

// File: tb/rtc_initctl_tb.sv
`timescale 1ns/1ps
module rtc_initctl_tb;

    localparam int A_W  = 7;
    localparam int S_W  = 15;
    localparam int SS_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            init_req = 1'b1;
    logic [A_W-1:0]  prediv_a = '0;
    logic [S_W-1:0]  prediv_s = '0;
    logic [1:0]      mode_sel = 2'b00;
    logic            fmt_wr = 1'b0;
    logic            fmt_wdata = 1'b0;
    logic            init_flag, count_en, tick_1hz, fmt_12h;
    logic [SS_W-1:0] subsec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rtc_initctl u_dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req),
        .prediv_a(prediv_a), .prediv_s(prediv_s), .mode_sel(mode_sel),
        .fmt_wr(fmt_wr), .fmt_wdata(fmt_wdata),
        .init_flag(init_flag), .count_en(count_en), .tick_1hz(tick_1hz),
        .subsec(subsec), .fmt_12h(fmt_12h)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic nx(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drop the request from ST_INIT, check the restart delay, leave at cycle 0
    task automatic start_run(input int pa, input int ps, input logic [1:0] md);
        prediv_a = A_W'(pa);
        prediv_s = S_W'(ps);
        mode_sel = md;
        init_req = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            nx(1);
            chk(count_en == 1'b0, "R4 restart hold", count_en, 0);
        end
        nx(1);
        chk(count_en == 1'b1, "R4 restart done", count_en, 1);
    endtask

    task automatic enter_init();
        init_req = 1'b1;
        nx(1);
        chk(count_en == 1'b0, "R2 run stops", count_en, 0);
        chk(init_flag == 1'b0, "R2 flag early 1", init_flag, 0);
        nx(1);
        chk(init_flag == 1'b0, "R2 flag early 2", init_flag, 0);
        nx(1);
        chk(init_flag == 1'b1, "R2 flag rises", init_flag, 1);
    endtask

    task automatic t_reset();
        chk(init_flag == 1'b1, "R1 flag", init_flag, 1);
        chk(count_en == 1'b0, "R1 count_en", count_en, 0);
        chk(tick_1hz == 1'b0, "R1 tick", tick_1hz, 0);
        chk(subsec == '0, "R1 subsec", subsec, 0);
        chk(fmt_12h == 1'b0, "R1 fmt", fmt_12h, 0);
    endtask

    task automatic t_bcd_tick(input int pa, input int ps);
        int per;
        per = (pa + 1) * (ps + 1);
        start_run(pa, ps, 2'b00);
        for (int c = 0; c < 2 * per + 5; c++) begin
            chk(tick_1hz == ((c % per) == per - 1), "R7 tick", tick_1hz, (c % per) == per - 1);
            chk(subsec == SS_W'(ps - ((c / (pa + 1)) % (ps + 1))), "R8 bcd subsec",
                subsec, ps - ((c / (pa + 1)) % (ps + 1)));
            nx(1);
        end
    endtask

    task automatic t_frozen();
        logic [SS_W-1:0] snap;
        enter_init();
        snap = subsec;
        for (int i = 0; i < 6; i++) begin
            nx(1);
            chk(subsec == snap, "R3 frozen", subsec, snap);
            chk(tick_1hz == 1'b0, "R11 no tick", tick_1hz, 0);
        end
    endtask

    task automatic t_binary(input logic [1:0] md);
        start_run(3, 4, md);
        for (int c = 0; c < 12; c++) begin
            chk(subsec == (32'hFFFF_FFFF - 32'(c / 4)), "R9 bin subsec",
                subsec, 32'hFFFF_FFFF - 32'(c / 4));
            nx(1);
        end
    endtask

    task automatic t_abort();
        init_req = 1'b1;
        nx(1);
        init_req = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            nx(1);
            chk(init_flag == 1'b0, "R5 flag stays low", init_flag, 0);
            chk(count_en == 1'b0, "R5 restart hold", count_en, 0);
        end
        nx(1);
        chk(count_en == 1'b1, "R5 restart done", count_en, 1);
    endtask

    task automatic t_req_in_restart();
        init_req = 1'b0;
        nx(1);
        init_req = 1'b1;
        nx(3);
        chk(count_en == 1'b0, "R6 still restarting", count_en, 0);
        nx(1);
        chk(count_en == 1'b1, "R6 one run cycle", count_en, 1);
        nx(1);
        chk(count_en == 1'b0, "R6 entry begins", count_en, 0);
        nx(1);
        chk(init_flag == 1'b0, "R6 flag not yet", init_flag, 0);
        nx(1);
        chk(init_flag == 1'b1, "R6 flag rises", init_flag, 1);
    endtask

    task automatic t_fmt();
        // running: write blocked
        fmt_wdata = 1'b1;
        fmt_wr = 1'b1;
        nx(1);
        fmt_wr = 1'b0;
        nx(1);
        chk(fmt_12h == 1'b0, "R10 blocked while running", fmt_12h, 0);
        enter_init();
        fmt_wr = 1'b1;
        nx(1);
        fmt_wr = 1'b0;
        chk(fmt_12h == 1'b1, "R10 write in init", fmt_12h, 1);
    endtask

    initial begin
        nx(3);
        rst_n = 1'b1;
        nx(1);
        t_reset();
        t_bcd_tick(3, 4);
        t_frozen();
        t_bcd_tick(1, 2);
        enter_init();
        t_binary(2'b01);
        enter_init();
        t_binary(2'b11);
        t_abort();
        nx(3);
        enter_init();
        t_req_in_restart();
        t_binary(2'b10);
        t_fmt();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule